// File: doc/BRIEF.md
# Parallel-Port Frame Read Transmitter

This block is a peripheral-side transmitter for an enhanced parallel port. Each acquisition cycle, internal logic delivers five 14-bit samples and a one-cycle frame-ready pulse. The block latches the samples and splits them into ten bytes. It raises the port interrupt line and then hands the bytes to the host, one per host read cycle.

The host runs each read cycle by pulling the data strobe low and later releasing it. The strobe is an asynchronous, possibly ringing line, so it is never used as a clock. It passes through a two-flop synchronizer on the system clock, and an edge detector follows. A synchronized falling edge loads the next byte and advances the byte index. The block then drives the byte, raises wait once the byte has settled, and drops both wait and the bus enable when it sees the strobe high again. After the tenth byte the block returns to idle. If a new frame-ready pulse arrives while a frame is still being read, the new frame is dropped and an overrun pulse is given.

Top module: `epp_frame_tx`

## Requirements
- R1: A frame-ready pulse while idle latches all samples, and the interrupt output is high from the next clock edge.
- R2: Byte 2k of a frame is bits 7:0 of sample k, and byte 2k+1 is the remaining upper bits of sample k, zero-extended, so bits 7:6 of every odd byte are 0. Samples go out in order 0 to 4.
- R3: A falling strobe, once synchronized (three clock edges after the input is low), drives the next byte with the bus enable high. The bus enable is never high unless the strobe was sampled low.
- R4: Wait rises one clock after the byte is driven, and the byte stays stable while wait is high. Wait and the bus enable both drop once the strobe is sampled high again.
- R5: The interrupt output drops when the host takes the first byte, and it is never high while the bus is driven.
- R6: After the tenth byte the block is idle: further strobes drive nothing, and the interrupt stays low.
- R7: A frame-ready pulse during a transfer gives a one-cycle overrun pulse. The current frame continues unchanged, and the new frame is dropped with no interrupt.
- R8: Strobe activity while idle is ignored: nothing is driven and the byte index does not move.
- R9: Sample inputs that change after the frame-ready pulse do not alter the bytes sent.
- R10: After reset, the interrupt, bus enable, wait and overrun outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_ready | input | 1 | One-cycle pulse: samples are valid |
| samples_flat | input | 70 | Five samples, sample k at bits 14k+13:14k |
| host_strobe_n | input | 1 | Host data strobe, active low, asynchronous |
| port_data_o | output | 8 | Byte driven onto the port data bus |
| port_data_oe | output | 1 | Data bus output enable |
| port_wait | output | 1 | Wait handshake to the host |
| port_irq | output | 1 | Interrupt request to the host |
| overrun | output | 1 | One-cycle pulse: a frame was dropped |

## Verification
Some properties are checked on every cycle. The bus enable only rises after the strobe input was low two edges earlier. Wait never appears without the bus enable, and the byte holds still under wait. The interrupt and the bus enable are never high together. Every interrupt rise and overrun pulse follows a frame-ready pulse.

Other behaviours only the bench scenarios can show. These are the byte order and zero-filled upper bits across several sample patterns, and the return to idle after ten bytes. They also include ignored strobes while idle, the dropped frame on overrun, and that later changes on the sample inputs do not reach the bytes sent.

// File: rtl/epp_tx_pkg.sv
// Shared types for the parallel-port frame transmitter.
package epp_tx_pkg;
    // Read-cycle controller states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // no frame pending
        ST_ARMED = 2'd1,  // frame held, waiting for strobe fall
        ST_DRIVE = 2'd2,  // byte driven, wait not yet raised
        ST_HOLD  = 2'd3   // wait raised, waiting for strobe high
    } rd_state_t;
endpackage

// File: rtl/epp_strobe_sync.sv
// Brings the asynchronous host strobe into the clock domain.
// Assumes: strobe is active low and may ring; its low and high phases
// last several clocks. Two flops resolve metastability, and a third
// holds the previous value for edge detection.
module epp_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n_async,
    output logic stb_fall,
    output logic stb_high
);
    logic meta_q, sync_q, prev_q;

    // Synchronizer chain and previous-value register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= strobe_n_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge and level outputs from the synchronized strobe.
    always_comb begin
        stb_fall = prev_q & ~sync_q;
        stb_high = sync_q;
    end
endmodule

// File: rtl/epp_frame_packer.sv
// Holds one frame of samples and selects the byte at a given index.
// Assumes: 9 <= SAMPLE_W <= 16. Even bytes carry sample bits 7:0 and
// odd bytes the upper bits, zero-extended.
module epp_frame_packer #(
    parameter int SAMPLE_W    = 14,
    parameter int NUM_SAMPLES = 5,
    localparam int NUM_BYTES  = 2 * NUM_SAMPLES,
    localparam int IDX_W      = $clog2(NUM_BYTES + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load,
    input  logic [NUM_SAMPLES*SAMPLE_W-1:0] samples_flat,
    input  logic [IDX_W-1:0]                sel,
    output logic [7:0]                      byte_out
);
    logic [NUM_SAMPLES*SAMPLE_W-1:0] frame_q;
    logic [7:0] bytes [NUM_BYTES];

    // Frame storage, loaded on the accepted frame-ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    frame_q <= '0;
        else if (load) frame_q <= samples_flat;
    end

    // Split each stored sample into its low and high byte.
    for (genvar k = 0; k < NUM_SAMPLES; k++) begin : g_split
        logic [15:0] ext;
        assign ext            = 16'(frame_q[k*SAMPLE_W +: SAMPLE_W]);
        assign bytes[2*k]     = ext[7:0];
        assign bytes[2*k + 1] = ext[15:8];
    end

    // Byte select; an index past the frame gives zero.
    always_comb begin
        byte_out = 8'h00;
        for (int b = 0; b < NUM_BYTES; b++)
            if (sel == IDX_W'(b)) byte_out = bytes[b];
    end
endmodule

// File: rtl/epp_read_ctrl.sv
// Read-cycle controller: interrupt, byte index, data, output enable, wait.
// Assumes: strobe edge and level come from the synchronizer. Only a
// falling edge advances the index. A frame-ready pulse outside idle is
// dropped and reported as overrun.
module epp_read_ctrl
    import epp_tx_pkg::*;
#(
    parameter int NUM_BYTES = 10,
    localparam int IDX_W    = $clog2(NUM_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_ready,
    input  logic             stb_fall,
    input  logic             stb_high,
    input  logic [7:0]       byte_in,
    output logic             load,
    output logic [IDX_W-1:0] idx,
    output logic [7:0]       data_o,
    output logic             oe,
    output logic             wait_o,
    output logic             irq,
    output logic             overrun
);
    localparam logic [IDX_W-1:0] END_IDX = IDX_W'(NUM_BYTES);

    rd_state_t state_q;

    // Accept a new frame only while idle.
    always_comb load = frame_ready && (state_q == ST_IDLE);

    // Handshake sequencing and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx     <= '0;
            data_o  <= 8'h00;
            oe      <= 1'b0;
            wait_o  <= 1'b0;
            irq     <= 1'b0;
            overrun <= 1'b0;
        end else begin
            overrun <= frame_ready && (state_q != ST_IDLE);
            case (state_q)
                ST_IDLE: begin
                    if (frame_ready) begin
                        idx     <= '0;
                        irq     <= 1'b1;
                        state_q <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (stb_fall) begin
                        data_o  <= byte_in;
                        oe      <= 1'b1;
                        irq     <= 1'b0;
                        idx     <= idx + 1'b1;
                        state_q <= ST_DRIVE;
                    end
                end
                ST_DRIVE: begin
                    wait_o  <= 1'b1;
                    state_q <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (stb_high) begin
                        oe      <= 1'b0;
                        wait_o  <= 1'b0;
                        state_q <= (idx == END_IDX) ? ST_IDLE : ST_ARMED;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/epp_frame_tx.sv
// Parallel-port frame transmitter top: latches five samples per frame,
// interrupts the host and serves ten strobe-driven byte reads.
// Assumes: host_strobe_n is asynchronous and is only sampled.
module epp_frame_tx #(
    parameter int SAMPLE_W    = 14,
    parameter int NUM_SAMPLES = 5,
    localparam int NUM_BYTES  = 2 * NUM_SAMPLES,
    localparam int IDX_W      = $clog2(NUM_BYTES + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            frame_ready,
    input  logic [NUM_SAMPLES*SAMPLE_W-1:0] samples_flat,
    input  logic                            host_strobe_n,
    output logic [7:0]                      port_data_o,
    output logic                            port_data_oe,
    output logic                            port_wait,
    output logic                            port_irq,
    output logic                            overrun
);
    logic             stb_fall, stb_high, load;
    logic [IDX_W-1:0] idx;
    logic [7:0]       sel_byte;

    epp_strobe_sync u_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n_async(host_strobe_n),
        .stb_fall(stb_fall), .stb_high(stb_high)
    );

    epp_frame_packer #(.SAMPLE_W(SAMPLE_W), .NUM_SAMPLES(NUM_SAMPLES)) u_pack (
        .clk(clk), .rst_n(rst_n), .load(load), .samples_flat(samples_flat),
        .sel(idx), .byte_out(sel_byte)
    );

    epp_read_ctrl #(.NUM_BYTES(NUM_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_ready(frame_ready),
        .stb_fall(stb_fall), .stb_high(stb_high), .byte_in(sel_byte),
        .load(load), .idx(idx), .data_o(port_data_o), .oe(port_data_oe),
        .wait_o(port_wait), .irq(port_irq), .overrun(overrun)
    );
endmodule

// File: rtl/epp_frame_tx_chk.sv
// Port-level protocol checker for epp_frame_tx, attached by bind.
module epp_frame_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_ready,
    input logic       host_strobe_n,
    input logic [7:0] port_data_o,
    input logic       port_data_oe,
    input logic       port_wait,
    input logic       port_irq,
    input logic       overrun
);
    // R3: bus enable rises only after the strobe input was low two edges earlier.
    a_r3_oe_after_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_data_oe) |-> !$past(host_strobe_n, 2));

    // R4: wait is only given while the bus is driven.
    a_r4_wait_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        port_wait |-> port_data_oe);

    // R4: the byte holds still while wait stays high.
    a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wait && $past(port_wait)) |-> $stable(port_data_o));

    // R5: interrupt and bus drive never coincide.
    a_r5_irq_not_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_irq && port_data_oe));

    // R1: interrupt rises only after a frame-ready pulse.
    a_r1_irq_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_irq) |-> $past(frame_ready));

    // R7: overrun only follows a frame-ready pulse.
    a_r7_overrun_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(frame_ready));
endmodule

bind epp_frame_tx epp_frame_tx_chk chk_i (
    .clk(clk), .rst_n(rst_n), .frame_ready(frame_ready),
    .host_strobe_n(host_strobe_n), .port_data_o(port_data_o),
    .port_data_oe(port_data_oe), .port_wait(port_wait),
    .port_irq(port_irq), .overrun(overrun)
);

// File: tb/epp_frame_tx_tb_top.sv
// Bench for epp_frame_tx: table-driven frames, then directed corner cases.
module epp_frame_tx_tb_top;
    localparam int SW = 14;
    localparam int NS = 5;
    localparam int NB = 2 * NS;
    localparam int NV = 4;

    // Stimulus table: sample values per frame.
    localparam logic [SW-1:0] VEC [NV][NS] = '{
        '{14'h0000, 14'h3FFF, 14'h0001, 14'h2000, 14'h00FF},
        '{14'h1234, 14'h2ABC, 14'h0F0F, 14'h3030, 14'h1FFE},
        '{14'h3FC0, 14'h003F, 14'h2A55, 14'h15AA, 14'h0100},
        '{14'h0ACE, 14'h3BDF, 14'h0777, 14'h2468, 14'h1357}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_ready = 1'b0;
    logic [NS*SW-1:0] samples_flat = '0;
    logic host_strobe_n = 1'b1;
    logic [7:0] port_data_o;
    logic port_data_oe, port_wait, port_irq, overrun;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    epp_frame_tx dut_i (
        .clk(clk), .rst_n(rst_n), .frame_ready(frame_ready),
        .samples_flat(samples_flat), .host_strobe_n(host_strobe_n),
        .port_data_o(port_data_o), .port_data_oe(port_data_oe),
        .port_wait(port_wait), .port_irq(port_irq), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected byte from the requirement's packing rule.
    function automatic logic [7:0] exp_byte(input int v, input int b);
        logic [15:0] e;
        e = 16'(VEC[v][b/2]);
        return (b % 2 == 0) ? e[7:0] : e[15:8];
    endfunction

    task automatic load_vec(input int v);
        for (int k = 0; k < NS; k++) samples_flat[k*SW +: SW] = VEC[v][k];
    endtask

    task automatic pulse_ready();
        frame_ready = 1'b1;
        @(negedge clk);
        frame_ready = 1'b0;
    endtask

    // One host read cycle; checks drive, wait and release.
    task automatic read_byte(input logic [7:0] exp, input string req);
        host_strobe_n = 1'b0;
        repeat (6) @(negedge clk);
        check(port_data_oe == 1'b1, "R3", "oe during strobe low", port_data_oe, 1);
        check(port_data_o == exp, req, "byte value", port_data_o, exp);
        check(port_wait == 1'b1, "R4", "wait raised", port_wait, 1);
        check(port_irq == 1'b0, "R5", "irq after byte taken", port_irq, 0);
        host_strobe_n = 1'b1;
        repeat (6) @(negedge clk);
        check(port_data_oe == 1'b0 && port_wait == 1'b0, "R4", "oe/wait released",
              {port_data_oe, port_wait}, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check({port_irq, port_data_oe, port_wait, overrun} == 4'b0, "R10", "reset outputs",
              {port_irq, port_data_oe, port_wait, overrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: strobe toggles while idle are ignored
        for (int t = 0; t < 3; t++) begin
            host_strobe_n = 1'b0;
            repeat (6) @(negedge clk);
            check(port_data_oe == 1'b0 && port_wait == 1'b0, "R8", "idle strobe drives nothing",
                  {port_data_oe, port_wait}, 0);
            host_strobe_n = 1'b1;
            repeat (6) @(negedge clk);
        end

        // Table walk: full frames (R1, R2, R6); the first byte also shows R8 index held.
        for (int v = 0; v < NV; v++) begin
            load_vec(v);
            pulse_ready();
            check(port_irq == 1'b1, "R1", "irq after frame ready", port_irq, 1);
            // R9: disturb inputs after latch
            samples_flat = ~samples_flat;
            for (int b = 0; b < NB; b++)
                read_byte(exp_byte(v, b), (b % 2) ? "R2" : "R9");
            // R6: extra strobe after tenth byte drives nothing
            host_strobe_n = 1'b0;
            repeat (6) @(negedge clk);
            check(port_data_oe == 1'b0 && port_irq == 1'b0, "R6", "idle after ten bytes",
                  {port_data_oe, port_irq}, 0);
            host_strobe_n = 1'b1;
            repeat (6) @(negedge clk);
        end

        // R7: frame-ready during a transfer
        load_vec(1);
        pulse_ready();
        for (int b = 0; b < 3; b++) read_byte(exp_byte(1, b), "R7");
        load_vec(2);
        frame_ready = 1'b1;
        @(negedge clk);
        frame_ready = 1'b0;
        check(overrun == 1'b1, "R7", "overrun pulse", overrun, 1);
        @(negedge clk);
        check(overrun == 1'b0, "R7", "overrun one cycle", overrun, 0);
        check(port_irq == 1'b0, "R7", "no irq for dropped frame", port_irq, 0);
        for (int b = 3; b < NB; b++) read_byte(exp_byte(1, b), "R7");
        repeat (3) @(negedge clk);
        check(port_irq == 1'b0, "R7", "dropped frame not armed", port_irq, 0);

        // R10: reset mid-frame clears outputs
        load_vec(3);
        pulse_ready();
        rst_n = 1'b0;
        @(negedge clk);
        check({port_irq, port_data_oe, port_wait, overrun} == 4'b0, "R10", "reset mid-frame",
              {port_irq, port_data_oe, port_wait, overrun}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule